// File: doc/BRIEF.md
# Flash Controller Interrupt and Recovery Unit

This unit gathers eight single-cycle event pulses from a serial flash controller's datapath. Each pulse is latched into a raw status word. A per-bit mask hides an event from the interrupt line without discarding it, and software acknowledges events through a write-one-to-clear register. The unmasked events are ORed together and drive one interrupt output, which is registered.

The unit also contains the controller's data FIFO. Transmit and receive share this one storage array. Software reads a status word with full and empty flags for each direction and with two fill levels: free entries for the transmit side and stored entries for the receive side.

A self-clearing recovery command empties the FIFO. It also holds the sequencer's reset output high for a fixed number of cycles, and during that time the command bit reads back as 1. Software reaches everything through a simple register port: a write strobe, a read strobe, a 3-bit word address and 32-bit data, with read data returned one cycle later.

Top module: `sfc_irq_recover_unit`

## Requirements
- R1: Event inputs latch into the raw status word (address 0) at fixed bit positions: 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 flash-side error, 7 DMA. After reset, raw status is 0, the mask (address 2) is 0xFF and the interrupt output is low.
- R2: A mask bit of 1 hides its source from the masked status word (address 1) and from the interrupt. The raw status word shows every latched event whatever the mask is. Writing 0xFF to the mask hides all sources.
- R3: Writing 1 to a bit of the clear register (address 3) clears that latched event. Writing the value read from raw status back to the clear register clears every pending event.
- R4: If an event and a clear of the same bit occur in the same cycle, the event wins and the bit stays set.
- R5: The interrupt output equals the OR of the masked status bits, delayed by one register stage.
- R6: Writing a word with bit 0 set to the recovery register (address 4) starts a recovery. For RCV_CYCLES cycles bit 0 of that register reads 1 and the sequencer reset output is high; after that both return to 0 without any further write. A recovery write while a recovery is already running is ignored.
- R7: Recovery empties the FIFO in the cycle it starts. Pushes and pops presented while it runs are ignored. It leaves the raw status and the mask unchanged.
- R8: The FIFO status word (address 5) has transmit full in bit 0, transmit empty in bit 1, receive empty in bit 2 and receive full in bit 3. It has the free-entry count in bits [12:8] and the stored-entry count in bits [20:16]. Both counts come from the same shared storage, so they always sum to the depth.
- R9: The FIFO returns words in the order they were pushed. A push while full and a pop while empty are ignored. An accepted pop presents its word with a valid flag one cycle later.
- R10: Reads return data one cycle after the read strobe. The clear register and the unused addresses 6 and 7 read 0. A recovery write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulses, one bit per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after the strobe |
| irq_o | output | 1 | Registered interrupt |
| seq_rst_o | output | 1 | Sequencer reset, high while a recovery runs |
| push_i | input | 1 | FIFO push request |
| push_data_i | input | DATA_W | FIFO push word |
| pop_i | input | 1 | FIFO pop request |
| pop_data_o | output | DATA_W | Popped word |
| pop_valid_o | output | 1 | Popped word valid |

## Verification
The assertions assume that event inputs and register strobes only change while reset is low and that reset is held for at least one clock edge. They also assume the FIFO depth is a power of two no larger than 31, so that both level fields fit. The bench drives every input half a cycle away from the sampling edge. It keeps the random stimulus to register writes, reads and sparse event pulses, with the depth fixed at 16. FIFO and recovery traffic are applied only in directed sequences, so a reference model kept in lock-step per cycle stays exact.

// File: rtl/sfc_irq_pkg.sv
package sfc_irq_pkg;
  localparam int SRC_N   = 8;
  localparam int REG_AW  = 3;
  localparam int REG_W   = 32;
  localparam int LVL_FW  = 5;

  // event source bit positions
  localparam int EV_RX_FULL  = 0;
  localparam int EV_RX_UFLOW = 1;
  localparam int EV_TX_OFLOW = 2;
  localparam int EV_TX_EMPTY = 3;
  localparam int EV_DONE     = 4;
  localparam int EV_BUS_ERR  = 5;
  localparam int EV_FLASH_ERR = 6;
  localparam int EV_DMA      = 7;

  // FIFO status word layout
  localparam int FS_TX_FULL  = 0;
  localparam int FS_TX_EMPTY = 1;
  localparam int FS_RX_EMPTY = 2;
  localparam int FS_RX_FULL  = 3;
  localparam int FS_TXLVL    = 8;
  localparam int FS_RXLVL    = 16;

  localparam int RCV_BIT = 0;

  typedef enum logic [REG_AW-1:0] {
    REG_RAW     = 3'd0,
    REG_MASKED  = 3'd1,
    REG_MASK    = 3'd2,
    REG_CLEAR   = 3'd3,
    REG_RECOVER = 3'd4,
    REG_FIFO    = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/sfc_irq_status.sv
module sfc_irq_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wd_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] masked_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q;
  logic [N-1:0] mask_q;
  logic         irq_q;

  // one latch per source; a new event outranks a clear of the same bit
  for (genvar b = 0; b < N; b++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[b] <= 1'b0;
      end else if (evt_i[b]) begin
        raw_q[b] <= 1'b1;
      end else if (clr_i[b]) begin
        raw_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wd_i;
      irq_q <= |(raw_q & ~mask_q);
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & ~mask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/sfc_recovery.sv
module sfc_recovery #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic flush_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i && (cnt_q == '0)) begin
      cnt_q <= CW'(CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign flush_o = start_i && (cnt_q == '0);
endmodule

// File: rtl/sfc_shared_fifo.sv
module sfc_shared_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush_i,
  input  logic                         hold_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                pop_data_o,
  output logic                         pop_valid_o,
  output logic [$clog2(DEPTH+1)-1:0]   fill_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && !hold_i && !flush_i && (fill_q != CW'(DEPTH));
  assign pop_ok  = pop_i  && !hold_i && !flush_i && (fill_q != '0);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) pop_data_o <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      fill_q      <= '0;
      pop_valid_o <= 1'b0;
    end else begin
      pop_valid_o <= pop_ok;
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  assign fill_o = fill_q;
endmodule

// File: rtl/sfc_irq_recover_unit.sv
module sfc_irq_recover_unit
  import sfc_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int RCV_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              seq_rst_o,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [SRC_N-1:0] raw, mask, masked, clr_vec;
  logic             mask_we, rcv_start, rcv_busy, rcv_flush;
  logic [CW-1:0]    fill;
  logic [REG_W-1:0] fifo_word;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:SRC_N];

  assign mask_we   = reg_wr_i && (reg_addr_i == REG_MASK);
  assign clr_vec   = (reg_wr_i && (reg_addr_i == REG_CLEAR)) ? reg_wdata_i[SRC_N-1:0] : '0;
  assign rcv_start = reg_wr_i && (reg_addr_i == REG_RECOVER) && reg_wdata_i[RCV_BIT];

  sfc_irq_status #(.N(SRC_N)) u_status (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .clr_i     (clr_vec),
    .mask_we_i (mask_we),
    .mask_wd_i (reg_wdata_i[SRC_N-1:0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .masked_o  (masked),
    .irq_o     (irq_o)
  );

  sfc_recovery #(.CYC(RCV_CYCLES)) u_recovery (
    .clk     (clk),
    .rst     (rst),
    .start_i (rcv_start),
    .busy_o  (rcv_busy),
    .flush_o (rcv_flush)
  );

  sfc_shared_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk         (clk),
    .rst         (rst),
    .flush_i     (rcv_flush),
    .hold_i      (rcv_busy),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o),
    .fill_o      (fill)
  );

  assign seq_rst_o = rcv_busy;

  always_comb begin
    fifo_word = '0;
    fifo_word[FS_TX_FULL]  = (fill == CW'(FIFO_DEPTH));
    fifo_word[FS_TX_EMPTY] = (fill == '0);
    fifo_word[FS_RX_EMPTY] = (fill == '0);
    fifo_word[FS_RX_FULL]  = (fill == CW'(FIFO_DEPTH));
    fifo_word[FS_TXLVL +: LVL_FW] = LVL_FW'(CW'(FIFO_DEPTH) - fill);
    fifo_word[FS_RXLVL +: LVL_FW] = LVL_FW'(fill);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else if (reg_rd_i) begin
      case (reg_addr_i)
        REG_RAW:     reg_rdata_o <= REG_W'(raw);
        REG_MASKED:  reg_rdata_o <= REG_W'(masked);
        REG_MASK:    reg_rdata_o <= REG_W'(mask);
        REG_RECOVER: reg_rdata_o <= REG_W'(rcv_busy);
        REG_FIFO:    reg_rdata_o <= fifo_word;
        default:     reg_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sfc_irq_recover_checker.sv
module sfc_irq_recover_checker #(
  parameter int N     = 8,
  parameter int DEPTH = 16,
  parameter int RCV   = 4,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  evt,
  input logic [N-1:0]  clr,
  input logic [N-1:0]  raw,
  input logic [N-1:0]  masked,
  input logic          irq,
  input logic          busy,
  input logic [CW-1:0] fill
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R4: a pulsed event is latched next cycle even under a clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));

  // R3: a cleared bit without a competing event is gone next cycle
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~evt)) |=> ((raw & $past(clr & ~evt)) == '0));

  // R5: interrupt follows masked status by one register stage
  a_r5_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|masked));

  // R6: recovery holds busy for exactly RCV cycles
  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == RCV));

  // R7: FIFO is empty once recovery is under way
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    busy |-> (fill == '0));

  // R9: occupancy never exceeds depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
endmodule

bind sfc_irq_recover_unit sfc_irq_recover_checker #(
  .N(sfc_irq_pkg::SRC_N), .DEPTH(FIFO_DEPTH), .RCV(RCV_CYCLES), .CW($clog2(FIFO_DEPTH + 1))
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .evt    (evt_i),
  .clr    (clr_vec),
  .raw    (raw),
  .masked (masked),
  .irq    (irq_o),
  .busy   (rcv_busy),
  .fill   (fill)
);

// File: tb/sfc_irq_recover_unit_test.sv
module sfc_irq_recover_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int RCV = 4;
  localparam logic [2:0] A_RAW = 0, A_MASKED = 1, A_MASK = 2, A_CLR = 3, A_RCV = 4, A_FIFO = 5;

  logic clk = 0, rst = 1;
  logic [7:0] evt = 0;
  logic wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, seq_rst, push = 0, pop = 0, pop_valid;
  logic [DW-1:0] push_data = 0, pop_data;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfc_irq_recover_unit #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .RCV_CYCLES(RCV)) uut (
    .clk(clk), .rst(rst), .evt_i(evt), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .seq_rst_o(seq_rst),
    .push_i(push), .push_data_i(push_data), .pop_i(pop), .pop_data_o(pop_data),
    .pop_valid_o(pop_valid));

  function automatic logic [31:0] fifo_exp(int cnt);
    logic [31:0] w = 0;
    w[0] = (cnt == DEPTH); w[1] = (cnt == 0); w[2] = (cnt == 0); w[3] = (cnt == DEPTH);
    w[12:8] = 5'(DEPTH - cnt); w[20:16] = 5'(cnt);
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d; tick(); wr = 0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    rd = 1; addr = a; tick(); rd = 0; d = rdata;
  endtask

  task automatic do_push(logic [DW-1:0] d);
    push = 1; push_data = d; tick(); push = 0;
  endtask

  task automatic do_pop(output logic [DW-1:0] d, output logic v);
    pop = 1; tick(); pop = 0; d = pop_data; v = pop_valid;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [DW-1:0] d;
    logic pv;
    logic [7:0] m_raw, m_mask;
    int ones, seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 0;
    tick();

    // reset state
    rd_reg(A_RAW, v);  check("R1 reset raw", v, 0);
    rd_reg(A_MASK, v); check("R1 reset mask", v, 32'hFF);
    check("R1 reset irq", 32'(irq), 0);
    rd_reg(A_FIFO, v); check("R8 reset fifo word", v, fifo_exp(0));

    // transfer-finished event (bit 4) while fully masked
    evt = 8'h10; tick(); evt = 0;
    rd_reg(A_RAW, v);    check("R1 raw bit4", v, 32'h10);
    rd_reg(A_MASKED, v); check("R2 masked hidden", v, 0);
    check("R2 irq stays low", 32'(irq), 0);
    wr_reg(A_MASK, 32'hEF);
    rd_reg(A_MASKED, v); check("R2 masked shows bit4", v, 32'h10);
    check("R5 irq high", 32'(irq), 1);
    evt = 8'h81; tick(); evt = 0;
    rd_reg(A_RAW, v);    check("R1 raw bits 0 7 4", v, 32'h91);
    wr_reg(A_CLR, v);
    rd_reg(A_RAW, v);    check("R3 write back clears all", v, 0);
    check("R5 irq low after clear", 32'(irq), 0);

    // same-cycle event and clear
    evt = 8'h20; wr_reg(A_CLR, 32'h20); evt = 0;
    rd_reg(A_RAW, v); check("R4 event beats clear", v, 32'h20);
    wr_reg(A_CLR, 32'hFF);
    wr_reg(A_MASK, 32'h00);
    m_raw = 0; m_mask = 0;

    // random register traffic against a per-cycle model
    for (int i = 0; i < 400; i++) begin
      int op;
      logic exp_irq;
      logic [31:0] exp_rd;
      logic [7:0] e, clr;
      e = 8'($urandom) & 8'($urandom) & 8'($urandom);
      op = int'($urandom % 4);
      clr = 0;
      evt = e; wr = 0; rd = 0;
      exp_irq = |(m_raw & ~m_mask);
      exp_rd = 0;
      case (op)
        0: begin wr = 1; addr = A_MASK; wdata = $urandom; end
        1: begin wr = 1; addr = A_CLR;  wdata = $urandom; clr = wdata[7:0]; end
        2: begin rd = 1; addr = A_RAW;  exp_rd = 32'(m_raw); end
        default: begin rd = 1; addr = A_MASKED; exp_rd = 32'(m_raw & ~m_mask); end
      endcase
      m_raw = (m_raw & ~clr) | e;
      if (op == 0) m_mask = wdata[7:0];
      tick();
      wr = 0; rd = 0; evt = 0;
      check("R5 random irq", 32'(irq), 32'(exp_irq));
      if (op >= 2) check("R2 random status read", rdata, exp_rd);
    end
    wr_reg(A_CLR, 32'hFF);
    wr_reg(A_MASK, 32'hFF);

    // FIFO ordering, levels, overflow and underflow
    for (int i = 1; i <= 5; i++) do_push(DW'(i));
    rd_reg(A_FIFO, v); check("R8 fifo five stored", v, fifo_exp(5));
    do_pop(d, pv); check("R9 pop first", d, 1); check("R9 pop valid", 32'(pv), 1);
    do_pop(d, pv); check("R9 pop second", d, 2);
    for (int i = 0; i < 20; i++) do_push(DW'(100 + i));
    rd_reg(A_FIFO, v); check("R8 fifo full word", v, fifo_exp(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] exp_d;
      exp_d = (i < 3) ? DW'(3 + i) : DW'(100 + i - 3);
      do_pop(d, pv);
      check("R9 drain order", d, exp_d);
    end
    do_pop(d, pv); check("R9 pop when empty ignored", 32'(pv), 0);
    rd_reg(A_FIFO, v); check("R8 fifo empty again", v, fifo_exp(0));

    // recovery
    for (int i = 0; i < 3; i++) do_push(DW'(50 + i));
    evt = 8'h40; tick(); evt = 0;
    wr_reg(A_RCV, 32'h1);
    check("R6 seq reset high", 32'(seq_rst), 1);
    ones = 0;
    for (int i = 0; i < RCV + 2; i++) begin
      rd_reg(A_RCV, v);
      if (v[0]) ones++;
    end
    check("R6 busy cycles", 32'(ones), 32'(RCV));
    check("R6 seq reset released", 32'(seq_rst), 0);
    rd_reg(A_FIFO, v); check("R7 fifo flushed", v, fifo_exp(0));
    rd_reg(A_RAW, v);  check("R7 raw kept", v, 32'h40);
    rd_reg(A_MASK, v); check("R7 mask kept", v, 32'hFF);
    wr_reg(A_RCV, 32'h1);
    do_push(DW'(77));
    repeat (RCV) tick();
    rd_reg(A_FIFO, v); check("R7 push during recovery ignored", v, fifo_exp(0));

    // register map corners
    wr_reg(A_RCV, 32'h2);
    check("R10 recovery bit0 clear no effect", 32'(seq_rst), 0);
    rd_reg(A_CLR, v);  check("R10 clear reads 0", v, 0);
    rd_reg(3'd6, v);   check("R10 addr 6 reads 0", v, 0);
    rd_reg(3'd7, v);   check("R10 addr 7 reads 0", v, 0);

    finish_run();
  end
endmodule